// File: doc/BRIEF.md
# Programmable Asynchronous Memory Read Strobe Timer

This block times one read access to a parallel, asynchronous NOR-type memory from the controller clock. When a start request is accepted, a tick counter begins at zero. The block drives three active-low strobes to the memory: chip select, address-valid and output enable. Each strobe has its own programmable assert tick and release tick. A separately programmed access tick chooses the cycle in which the memory data bus is captured. A cycle-length field ends the access with a one-cycle done pulse.

A single granularity input doubles every programmed timing value. Slow devices can then be covered with narrow timing fields. All timing inputs are sampled when the cycle starts, so software may rewrite them during an access without disturbing it.

Top module: `async_rd_timer`

## Requirements
- R1: After reset all three strobes (`cs_n_o`, `adv_n_o`, `oe_n_o`) are high, `done_o` is low and `rd_data_o` is zero.
- R2: A start request seen at a clock edge while idle begins a cycle whose tick counter is 0 during the following clock period and rises by one each clock. The cycle lasts L ticks, where L is the scaled cycle field.
- R3: During tick k of a cycle, each strobe is low exactly when its scaled assert value <= k < its scaled release value; otherwise it is high.
- R4: A strobe whose scaled release value is not greater than its scaled assert value stays high for the whole cycle.
- R5: With `gran_i` = 1 at cycle start, every timing field (three assert, three release, access, cycle) is multiplied by two before use; with `gran_i` = 0 it is used as is.
- R6: `rd_data_o` takes the value of `mem_data_i` present during tick k = scaled access value, provided that tick lies inside the cycle. At every other time `rd_data_o` holds its value.
- R7: `done_o` is high for exactly one clock, during the last tick (k = L-1). In the clock after that, the block is idle with all strobes high.
- R8: A start request that arrives while a cycle is in progress, including its last tick, is ignored: the running cycle neither restarts nor lengthens.
- R9: Changes to any timing input or to `gran_i` during a cycle have no effect on that cycle.
- R10: A scaled cycle value of 0 gives a cycle of one tick (done in tick 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read cycle request |
| gran_i | input | 1 | Doubles all timing fields when 1 |
| cs_on_i | input | TW | Chip-select assert tick |
| cs_off_i | input | TW | Chip-select release tick |
| adv_on_i | input | TW | Address-valid assert tick |
| adv_off_i | input | TW | Address-valid release tick |
| oe_on_i | input | TW | Output-enable assert tick |
| oe_off_i | input | TW | Output-enable release tick |
| acc_i | input | TW | Data capture tick |
| cyc_i | input | TW | Cycle length in ticks |
| mem_data_i | input | DW | Memory data bus |
| cs_n_o | output | 1 | Active-low chip select |
| adv_n_o | output | 1 | Active-low address valid |
| oe_n_o | output | 1 | Active-low output enable |
| rd_data_o | output | DW | Captured read word |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench checks the strobes and `done_o` against the expected waveform in every tick of every cycle, so a counter that slips or starts at the wrong value shows as a misplaced strobe edge within one clock of the fault. A wrong latched timing value or a missed doubling moves an edge or the done pulse in the same cycle. A wrong capture point shows in `rd_data_o` at the end of the access, because the memory bus carries a different word in each tick. A busy flag that fails to clear or set shows as missing idle-high strobes, or as a restarted cycle, one clock after the last tick.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int unsigned MAX_TW = 8;
  localparam int unsigned NSTROBE = 3;

  typedef enum logic [1:0] {
    STB_CS  = 2'd0,
    STB_ADV = 2'd1,
    STB_OE  = 2'd2
  } strobe_e;

  // Applies the granularity multiplier to one timing field.
  function automatic logic [MAX_TW:0] scale_tick(input logic [MAX_TW-1:0] val, input logic dbl);
    scale_tick = dbl ? {val, 1'b0} : {1'b0, val};
  endfunction

  // True when tick k lies in the half-open window [on, off).
  function automatic logic in_window(input logic [MAX_TW:0] k, input logic [MAX_TW:0] on_t,
                                     input logic [MAX_TW:0] off_t);
    in_window = (k >= on_t) && (k < off_t);
  endfunction
endpackage

// File: rtl/art_seq.sv
module art_seq #(
  parameter int unsigned CNTW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CNTW-1:0] acc_s,
  input  logic [CNTW-1:0] cyc_s,
  output logic            busy,
  output logic [CNTW-1:0] count,
  output logic            start_acc,
  output logic            last_tick,
  output logic            cap_evt
);
  logic [CNTW:0] next_k;

  assign start_acc = start_i && !busy;
  assign next_k    = {1'b0, count} + 1'b1;
  assign last_tick = busy && (next_k >= {1'b0, cyc_s});
  assign cap_evt   = busy && (count == acc_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (start_acc) begin
      busy  <= 1'b1;
      count <= '0;
    end else if (last_tick) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (busy) begin
      count <= count + 1'b1;
    end
  end

  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_tick) |=> (busy && count == $past(count) + 1'b1));
  a_r2_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && count == '0));
  a_r7_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !busy);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !last_tick) |=> count != '0);
endmodule

// File: rtl/art_strobe.sv
module art_strobe #(
  parameter int unsigned CNTW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic [CNTW-1:0] count,
  input  logic [CNTW-1:0] on_s,
  input  logic [CNTW-1:0] off_s,
  output logic            str_n
);
  import art_pkg::*;

  logic active;
  assign active = busy && in_window(MAX_TW'(count) , MAX_TW'(on_s), MAX_TW'(off_s)) ;
  assign str_n  = !active;

  a_r4_empty_window_high: assert property (@(posedge clk) disable iff (!rst_n)
    (off_s <= on_s) |-> str_n);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> str_n);
endmodule

// File: rtl/art_capture.sv
module art_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_evt,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (cap_evt) rd_data <= mem_data_i;
  end

  a_r6_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(rd_data));
  a_r6_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> rd_data == $past(mem_data_i));
endmodule

// File: rtl/async_rd_timer.sv
module async_rd_timer #(
  parameter int unsigned TW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          gran_i,
  input  logic [TW-1:0] cs_on_i,
  input  logic [TW-1:0] cs_off_i,
  input  logic [TW-1:0] adv_on_i,
  input  logic [TW-1:0] adv_off_i,
  input  logic [TW-1:0] oe_on_i,
  input  logic [TW-1:0] oe_off_i,
  input  logic [TW-1:0] acc_i,
  input  logic [TW-1:0] cyc_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          cs_n_o,
  output logic          adv_n_o,
  output logic          oe_n_o,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o
);
  import art_pkg::*;

  localparam int unsigned CNTW = TW + 1;
  localparam int unsigned NS   = NSTROBE;

  // Timing fields sampled at cycle start (R9).
  logic                   gran_q;
  logic [NS-1:0][TW-1:0]  on_q, off_q;
  logic [TW-1:0]          acc_q, cyc_q;

  logic [NS-1:0][TW-1:0]  on_in, off_in;
  logic [NS-1:0][CNTW-1:0] on_s, off_s;
  logic [CNTW-1:0]        acc_s, cyc_s;
  logic [NS-1:0]          str_n;

  logic                   busy, start_acc, last_tick, cap_evt;
  logic [CNTW-1:0]        count;

  assign on_in[STB_CS]   = cs_on_i;
  assign on_in[STB_ADV]  = adv_on_i;
  assign on_in[STB_OE]   = oe_on_i;
  assign off_in[STB_CS]  = cs_off_i;
  assign off_in[STB_ADV] = adv_off_i;
  assign off_in[STB_OE]  = oe_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gran_q <= 1'b0;
      on_q   <= '0;
      off_q  <= '0;
      acc_q  <= '0;
      cyc_q  <= '0;
    end else if (start_acc) begin
      gran_q <= gran_i;
      on_q   <= on_in;
      off_q  <= off_in;
      acc_q  <= acc_i;
      cyc_q  <= cyc_i;
    end
  end

  assign acc_s = CNTW'(scale_tick(MAX_TW'(acc_q), gran_q));
  assign cyc_s = CNTW'(scale_tick(MAX_TW'(cyc_q), gran_q));

  art_seq #(.CNTW(CNTW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .acc_s     (acc_s),
    .cyc_s     (cyc_s),
    .busy      (busy),
    .count     (count),
    .start_acc (start_acc),
    .last_tick (last_tick),
    .cap_evt   (cap_evt)
  );

  for (genvar g = 0; g < NS; g++) begin : g_stb
    assign on_s[g]  = CNTW'(scale_tick(MAX_TW'(on_q[g]), gran_q));
    assign off_s[g] = CNTW'(scale_tick(MAX_TW'(off_q[g]), gran_q));

    art_strobe #(.CNTW(CNTW)) u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (busy),
      .count (count),
      .on_s  (on_s[g]),
      .off_s (off_s[g]),
      .str_n (str_n[g])
    );
  end

  art_capture #(.DW(DW)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_evt    (cap_evt),
    .mem_data_i (mem_data_i),
    .rd_data    (rd_data_o)
  );

  assign cs_n_o  = str_n[STB_CS];
  assign adv_n_o = str_n[STB_ADV];
  assign oe_n_o  = str_n[STB_OE];
  assign done_o  = last_tick;

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_acc) |=> ($stable(cyc_q) && $stable(acc_q) && $stable(gran_q)));
  a_r5_scaling_even: assert property (@(posedge clk) disable iff (!rst_n)
    gran_q |-> (cyc_s[0] == 1'b0 && acc_s[0] == 1'b0));
endmodule

// File: tb/tb_async_rd_timer.sv
module tb_async_rd_timer;
  localparam int unsigned TW = 6;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, gran_i = 1'b0;
  logic [TW-1:0] cs_on_i = '0, cs_off_i = '0, adv_on_i = '0, adv_off_i = '0;
  logic [TW-1:0] oe_on_i = '0, oe_off_i = '0, acc_i = '0, cyc_i = '0;
  logic [DW-1:0] mem_data_i = '0;
  logic cs_n_o, adv_n_o, oe_n_o, done_o;
  logic [DW-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_data = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  async_rd_timer #(.TW(TW), .DW(DW)) dut (.*);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sc(input int v, input bit g);
    return g ? v * 2 : v;
  endfunction

  function automatic bit exp_low(input int k, input int on_t, input int off_t);
    return (k >= on_t) && (k < off_t);
  endfunction

  function automatic logic [DW-1:0] bus_word(input int k, input logic [DW-1:0] pat);
    return pat ^ DW'(k * 16'h0101 + 16'h0035);
  endfunction

  // One read cycle. perturb: mid-cycle start pulses and changed fields.
  task automatic run_cycle(input bit g, input int cson, input int csoff, input int advon,
                           input int advoff, input int oeon, input int oeoff, input int acc,
                           input int cyc, input bit perturb, input string tag);
    int len, a_s;
    logic [DW-1:0] pat;
    pat = DW'($urandom);
    @(negedge clk);
    gran_i = g; cs_on_i = TW'(cson); cs_off_i = TW'(csoff);
    adv_on_i = TW'(advon); adv_off_i = TW'(advoff);
    oe_on_i = TW'(oeon); oe_off_i = TW'(oeoff);
    acc_i = TW'(acc); cyc_i = TW'(cyc);
    start_i = 1'b1;
    len = sc(cyc, g);
    if (len == 0) len = 1;   // R10
    a_s = sc(acc, g);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      mem_data_i = bus_word(k, pat);
      if (perturb && (k == 2 || k == 3)) begin
        start_i = 1'b1;                       // R8
        gran_i = ~g; cyc_i = TW'($urandom);   // R9
        cs_off_i = TW'($urandom); oe_on_i = TW'($urandom); acc_i = TW'($urandom);
      end
      check({tag, " R3"}, "cs_n", cs_n_o, !exp_low(k, sc(cson, g), sc(csoff, g)));
      check({tag, " R3"}, "adv_n", adv_n_o, !exp_low(k, sc(advon, g), sc(advoff, g)));
      check({tag, " R3"}, "oe_n", oe_n_o, !exp_low(k, sc(oeon, g), sc(oeoff, g)));
      check({tag, " R7"}, "done", done_o, (k == len - 1));
      if (k == a_s) exp_data = mem_data_i;    // R6
    end
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R7"}, "idle strobes", {cs_n_o, adv_n_o, oe_n_o}, 3'b111);
    check({tag, " R7"}, "done after end", done_o, 0);
    check({tag, " R6"}, "rd_data", rd_data_o, exp_data);
    @(negedge clk);
    check({tag, " R8"}, "no restart", {cs_n_o, adv_n_o, oe_n_o, done_o}, 4'b1110);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "cs_n", cs_n_o, 1);
    check("R1", "adv_n", adv_n_o, 1);
    check("R1", "oe_n", oe_n_o, 1);
    check("R1", "done", done_o, 0);
    check("R1", "rd_data", rd_data_o, 0);
    rst_n = 1'b1;
    // R2 R5: example settings with doubling (30/38/34/2/34 ticks)
    run_cycle(1, 0, 'h11, 0, 'h01, 0, 'h11, 'h0F, 'h13, 0, "example");
    // R5: same fields without doubling
    run_cycle(0, 0, 'h11, 0, 'h01, 0, 'h11, 'h0F, 'h13, 0, "nogran");
    // R4: reversed and equal windows stay high
    run_cycle(0, 9, 3, 5, 5, 2, 7, 4, 12, 0, "empty_win");
    // R10: zero cycle length, capture at tick 0
    run_cycle(1, 0, 1, 0, 1, 0, 1, 0, 0, 0, "zero_cyc");
    // R6: capture point beyond cycle end leaves data held
    run_cycle(0, 1, 4, 0, 2, 1, 6, 20, 8, 0, "late_acc");
    // R8 R9: mid-cycle start pulses and field changes
    run_cycle(1, 1, 9, 0, 2, 2, 9, 5, 11, 1, "perturb");
    for (int i = 0; i < 30; i++) begin
      run_cycle(1'($urandom), $urandom % 40, $urandom % 40, $urandom % 40, $urandom % 40,
                $urandom % 40, $urandom % 40, $urandom % 40, $urandom % 40, 1'($urandom),
                "random");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule